// File: doc/BRIEF.md
# Next-PC Unit with Branch Delay Slot

This block sits in the fetch stage of a 32-bit RISC core whose branches and jumps have one delay slot. It holds the address of the instruction being fetched and advances it every clock. In each cycle the decode stage presents the control-flow operation of the instruction at that address, along with both source register values, the 16-bit immediate and the 26-bit jump index.

When the operation is a taken branch or a jump, the block does not redirect fetch at once. The next instruction, which is the delay-slot instruction, is still fetched and executed. The resolved target is kept in a pending register and becomes the fetch address one cycle later.

For the linking operations the block also raises a write request for register 31. The return value skips the delay slot, so it is the address of the linking instruction plus 8. Instruction memory, the register file and any prediction are outside this block.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` is the `RESET_VEC` parameter and any pending redirect is dropped. The first cycle after release fetches `RESET_VEC`, and the cycle after that fetches `RESET_VEC`+4.
- R2: When no redirect is pending and the current operation is `op_code` 0 (no control flow), the next `fetch_pc` is `fetch_pc`+4.
- R3: After a taken branch or jump at address P, the next fetch is always P+4 (the delay slot). The fetch after that is the target.
- R4: A taken conditional branch at address P targets P+4 plus `imm16` sign-extended and shifted left by two, so negative offsets are supported.
- R5: `op_code` 1 branches when `rs_val` equals `rt_val`, and `op_code` 2 branches when they differ.
- R6: Compares against zero treat `rs_val` as signed: `op_code` 3 branches on <=0, 4 on >0, 5 on <0, 6 on >=0. The link forms 7 (<0) and 8 (>=0) use the same tests.
- R7: `op_code` 9 (direct jump) and 10 (direct jump with link) at address P target {P[31:28], `jidx`, 2'b00}.
- R8: `op_code` 11 (register jump) and 12 (register jump with link) target `rs_val`.
- R9: For `op_code` 7, 8, 10 and 12, `link_we` is high in the same cycle and `link_data` is `fetch_pc`+8. The branch-and-link forms raise it whether or not the branch is taken. For every other code, `link_we` is low.
- R10: A conditional branch whose test fails causes no redirect, so fetch continues sequentially.
- R11: A taken branch placed in a delay slot computes its target from its own address. That redirect takes effect after the instruction fetched from the first branch's target.
- R12: Codes 13 to 15 behave like code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Control-flow operation of the instruction at `fetch_pc` |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| imm16 | input | 16 | Branch offset field |
| jidx | input | 26 | Direct jump index field |
| fetch_pc | output | 32 | Address of the instruction being fetched |
| link_we | output | 1 | Write request for register 31 |
| link_data | output | 32 | Return address to write |

## Verification
Two functions can fall in the same cycle: applying a pending redirect, and recording a new one when the instruction in the delay slot is itself a taken branch. The bench provokes this by putting a taken equality branch in the slot of another taken branch. It then expects fetch to reach the first target and, one instruction later, the target computed from the slot branch's own address. It also checks link requests that coincide with not-taken branches, where the write must happen without any redirect.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int XLEN     = 32;
    localparam int IMM_W    = 16;
    localparam int JIDX_W   = 26;
    localparam int OP_W     = 4;
    localparam int REGION_W = XLEN - JIDX_W - 2;
    localparam int SEXT_W   = XLEN - IMM_W - 2;

    typedef enum logic [OP_W-1:0] {
        FL_NONE   = 4'd0,
        FL_EQ     = 4'd1,
        FL_NE     = 4'd2,
        FL_LEZ    = 4'd3,
        FL_GTZ    = 4'd4,
        FL_LTZ    = 4'd5,
        FL_GEZ    = 4'd6,
        FL_LTZ_LK = 4'd7,
        FL_GEZ_LK = 4'd8,
        FL_JDIR   = 4'd9,
        FL_JDIR_LK= 4'd10,
        FL_JREG   = 4'd11,
        FL_JREG_LK= 4'd12
    } flow_op_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            pend_v;
        logic [XLEN-1:0] pend_tgt;
    } npc_state_t;

    function automatic logic op_links(flow_op_e op);
        return (op == FL_LTZ_LK) || (op == FL_GEZ_LK) ||
               (op == FL_JDIR_LK) || (op == FL_JREG_LK);
    endfunction
endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  flow_op_e        op,
    input  logic [XLEN-1:0] a_val,
    input  logic [XLEN-1:0] b_val,
    output logic            take
);
    logic a_neg;
    logic a_zero;
    logic same;

    always_comb begin
        a_neg  = a_val[XLEN-1];
        a_zero = (a_val == '0);
        same   = (a_val == b_val);
        unique case (op)
            FL_EQ:                  take = same;
            FL_NE:                  take = !same;
            FL_LEZ:                 take = a_neg || a_zero;
            FL_GTZ:                 take = !a_neg && !a_zero;
            FL_LTZ,  FL_LTZ_LK:     take = a_neg;
            FL_GEZ,  FL_GEZ_LK:     take = !a_neg;
            FL_JDIR, FL_JDIR_LK,
            FL_JREG, FL_JREG_LK:    take = 1'b1;
            default:                take = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  flow_op_e          op,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   reg_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [JIDX_W-1:0] jidx,
    output logic [XLEN-1:0]   dest
);
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_off;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] dir_tgt;

    always_comb begin
        seq_pc  = pc + XLEN'(4);
        rel_off = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        rel_tgt = seq_pc + rel_off;
        dir_tgt = {pc[XLEN-1 -: REGION_W], jidx, 2'b00};
        unique case (op)
            FL_JDIR, FL_JDIR_LK: dest = dir_tgt;
            FL_JREG, FL_JREG_LK: dest = reg_val;
            default:             dest = rel_tgt;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     op_code,
    input  logic [XLEN-1:0]     rs_val,
    input  logic [XLEN-1:0]     rt_val,
    input  logic [IMM_W-1:0]    imm16,
    input  logic [JIDX_W-1:0]   jidx,
    output logic [XLEN-1:0]     fetch_pc,
    output logic                link_we,
    output logic [XLEN-1:0]     link_data
);
    flow_op_e        op;
    logic            take;
    logic [XLEN-1:0] dest;
    npc_state_t      st_d;
    npc_state_t      st_q;

    assign op = flow_op_e'(op_code);

    npc_cond u_cond (
        .op    (op),
        .a_val (rs_val),
        .b_val (rt_val),
        .take  (take)
    );

    npc_target u_tgt (
        .op      (op),
        .pc      (st_q.pc),
        .reg_val (rs_val),
        .imm     (imm16),
        .jidx    (jidx),
        .dest    (dest)
    );

    always_comb begin
        st_d          = st_q;
        st_d.pc       = st_q.pend_v ? st_q.pend_tgt : st_q.pc + XLEN'(4);
        st_d.pend_v   = take;
        st_d.pend_tgt = take ? dest : st_q.pend_tgt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc       <= RESET_VEC;
            st_q.pend_v   <= 1'b0;
            st_q.pend_tgt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc  = st_q.pc;
    assign link_we   = op_links(op);
    assign link_data = st_q.pc + XLEN'(8);

    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend_v && !take) |=> (fetch_pc == $past(fetch_pc) + 32'd4));

    a_r3_slot_first: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !st_q.pend_v) |=> (fetch_pc == $past(fetch_pc) + 32'd4) && st_q.pend_v);

    a_r11_apply_pending: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend_v |=> (fetch_pc == $past(st_q.pend_tgt)));

    a_r8_reg_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (op == FL_JREG && !st_q.pend_v) |=> ##1 (fetch_pc == $past(rs_val, 2)));

    a_r9_plain_jump_no_link: assert property (@(posedge clk) disable iff (!rst_n)
        (op == FL_JDIR || op == FL_JREG || op == FL_EQ) |-> !link_we);
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
    localparam logic [31:0] RV = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm16 = '0;
    logic [25:0] jidx = '0;
    logic [31:0] fetch_pc;
    logic        link_we;
    logic [31:0] link_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    npc_unit #(.RESET_VEC(RV)) uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .rs_val(rs_val),
        .rt_val(rt_val), .imm16(imm16), .jidx(jidx),
        .fetch_pc(fetch_pc), .link_we(link_we), .link_data(link_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] i, input logic [25:0] j);
        op_code = o; rs_val = a; rt_val = b; imm16 = i; jidx = j;
        #1;
    endtask

    task automatic tick();
        @(negedge clk);
        op_code = 4'd0;
        #1;
    endtask

    // branch at P, nop in slot, then expect target
    task automatic branch_pair(input string req, input logic [3:0] o, input logic [31:0] a,
                               input logic [31:0] b, input logic [15:0] i, input bit taken,
                               input logic [31:0] tgt);
        logic [31:0] p;
        p = fetch_pc;
        drive(o, a, b, i, '0);
        tick();
        chk({req, " slot"}, fetch_pc, p + 32'd4);
        tick();
        chk(req, fetch_pc, taken ? tgt : p + 32'd8);
    endtask

    task automatic t_reset();
        chk("R1 reset pc", fetch_pc, RV);
        tick();
        chk("R2 sequential", fetch_pc, RV + 32'd4);
        tick();
        chk("R2 sequential 2", fetch_pc, RV + 32'd8);
        drive(4'd0, 32'h1, 32'h2, 16'h7, '0);
        chk("R9 no link on nop", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_two_reg();
        logic [31:0] p;
        p = fetch_pc;
        branch_pair("R3 R4 R5 beq taken", 4'd1, 32'd5, 32'd5, 16'd3, 1'b1, p + 32'd16);
        p = fetch_pc;
        branch_pair("R5 R10 bne not taken", 4'd2, 32'd9, 32'd9, 16'd3, 1'b0, 32'd0);
        p = fetch_pc;
        branch_pair("R4 R5 bne negative", 4'd2, 32'd1, 32'd2, 16'hFFFE, 1'b1, p - 32'd4);
        branch_pair("R5 R10 beq not taken", 4'd1, 32'd1, 32'd2, 16'd8, 1'b0, 32'd0);
    endtask

    task automatic t_zero();
        logic [31:0] p;
        p = fetch_pc;
        branch_pair("R6 blez zero", 4'd3, 32'd0, 32'd0, 16'd2, 1'b1, p + 32'd12);
        branch_pair("R6 bgtz neg", 4'd4, 32'h8000_0000, 32'd0, 16'd2, 1'b0, 32'd0);
        p = fetch_pc;
        branch_pair("R6 bgtz pos", 4'd4, 32'd1, 32'd0, 16'd1, 1'b1, p + 32'd8);
        p = fetch_pc;
        branch_pair("R6 bltz neg", 4'd5, 32'h8000_0000, 32'd0, 16'd5, 1'b1, p + 32'd24);
        p = fetch_pc;
        branch_pair("R6 bgez zero", 4'd6, 32'd0, 32'd0, 16'd1, 1'b1, p + 32'd8);
        branch_pair("R6 bltz pos", 4'd5, 32'h7FFF_FFFF, 32'd0, 16'd5, 1'b0, 32'd0);
    endtask

    task automatic t_jumps();
        logic [31:0] p;
        p = fetch_pc;
        drive(4'd9, '0, '0, '0, 26'h0AB_CDEF);
        chk("R9 no link on jump", {31'd0, link_we}, 32'd0);
        tick();
        chk("R3 jump slot", fetch_pc, p + 32'd4);
        tick();
        chk("R7 direct target", fetch_pc, {p[31:28], 26'h0AB_CDEF, 2'b00});
        p = fetch_pc;
        drive(4'd11, 32'h0040_0200, '0, '0, '0);
        tick();
        chk("R3 jr slot", fetch_pc, p + 32'd4);
        tick();
        chk("R8 register target", fetch_pc, 32'h0040_0200);
    endtask

    task automatic t_link();
        logic [31:0] p;
        p = fetch_pc;
        drive(4'd10, '0, '0, '0, 26'h10_0040);
        chk("R9 jal we", {31'd0, link_we}, 32'd1);
        chk("R9 jal data", link_data, p + 32'd8);
        tick();
        tick();
        chk("R7 jal target", fetch_pc, {p[31:28], 26'h10_0040, 2'b00});
        p = fetch_pc;
        drive(4'd7, 32'd1, '0, 16'd4, '0);
        chk("R9 bltzal not taken we", {31'd0, link_we}, 32'd1);
        chk("R9 bltzal data", link_data, p + 32'd8);
        tick();
        tick();
        chk("R10 bltzal no redirect", fetch_pc, p + 32'd8);
        p = fetch_pc;
        drive(4'd8, 32'd3, '0, 16'd2, '0);
        chk("R9 bgezal we", {31'd0, link_we}, 32'd1);
        tick();
        tick();
        chk("R6 bgezal target", fetch_pc, p + 32'd12);
        p = fetch_pc;
        drive(4'd12, 32'h0040_0800, '0, '0, '0);
        chk("R9 jalr data", link_data, p + 32'd8);
        tick();
        tick();
        chk("R8 jalr target", fetch_pc, 32'h0040_0800);
    endtask

    task automatic t_slot_branch();
        logic [31:0] p;
        p = fetch_pc;
        drive(4'd1, 32'd4, 32'd4, 16'd4, '0);
        tick();
        chk("R11 slot fetch", fetch_pc, p + 32'd4);
        drive(4'd1, 32'd6, 32'd6, 16'd1, '0);
        tick();
        chk("R11 first target", fetch_pc, p + 32'd20);
        tick();
        chk("R11 second target", fetch_pc, p + 32'd12);
        tick();
        chk("R2 after redirects", fetch_pc, p + 32'd16);
    endtask

    task automatic t_unused_codes();
        logic [31:0] p;
        p = fetch_pc;
        drive(4'd14, 32'd0, 32'd0, 16'd9, 26'h3);
        chk("R12 no link", {31'd0, link_we}, 32'd0);
        tick();
        tick();
        chk("R12 no redirect", fetch_pc, p + 32'd8);
    endtask

    task automatic t_reset_drops_pending();
        drive(4'd9, '0, '0, '0, 26'h155);
        @(negedge clk);
        rst_n = 1'b0;
        op_code = 4'd0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset again", fetch_pc, RV);
        tick();
        chk("R1 pending dropped", fetch_pc, RV + 32'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_two_reg();
        t_zero();
        t_jumps();
        t_link();
        t_slot_branch();
        t_unused_codes();
        t_reset_drops_pending();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule